// File: doc/BRIEF.md
# OTP Program Unlock Controller

This block sits behind the control register of a one-time-programmable memory. It keeps the program command locked until the host writes a fixed three-value key into a 3-bit access field. It also holds the program and verify request bits. The host sets these bits, and the device clears them when the memory engine reports completion. When a verify operation finishes, the block latches the pass/fail answer into a fault status bit.

The host writes the register through `wr_en` and `wr_data`. A one-cycle start strobe goes to the OTP engine for each accepted request. The engine reports back through `eng_busy` and `eng_done`, and gives the verify outcome on `ver_pass`. A separate input, `prereq_ok`, tells the block that the rest of the chip is configured safely. Without it, no program request is accepted.

Top module: `otp_unlock_ctrl`

## Requirements
- R1: After reset, the register read-back, both start strobes and the fault bit are all 0.
- R2: The access field (register bits 3..1) unlocks after three consecutive writes carrying 2, then 1, then 4. While unlocked it reads back as 7; at every other time it reads back as 0.
- R3: While the key is being entered, a write whose field is not the next expected value returns the sequence to its start. This includes repeating a 2 after a 2. That write does not itself count as a first key.
- R4: Any write while unlocked relocks the field, so it reads 0 after that write. This holds even when the write carries 2, 1 or 4, and that write does not begin a new key sequence.
- R5: A write with the program bit (bit 0) set is accepted only if the field was unlocked before the write and `prereq_ok` is high. Acceptance sets the program request bit and pulses `prog_start`, both in the cycle after the write.
- R6: A program write made while locked, or while `prereq_ok` is low, leaves the program bit at 0 and raises no strobe.
- R7: A write with the verify bit (bit 4) set, when not busy, sets the verify request bit and pulses `ver_start` in the next cycle. No unlock is needed.
- R8: A write that sets both the program and verify bits is rejected. Neither request bit changes and no strobe fires, so both request bits are never 1 together.
- R9: While either request bit is 1 or `eng_busy` is high, program and verify writes are ignored.
- R10: `eng_done` clears the pending request bit in the following cycle.
- R11: When a verify completes, the fault bit takes the inverse of `ver_pass`. At all other times it holds its value.
- R12: Each start strobe is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data: bit 4 verify, bits 3..1 access key, bit 0 program |
| prereq_ok | input | 1 | External program prerequisites satisfied |
| eng_busy | input | 1 | OTP engine busy |
| eng_done | input | 1 | OTP engine finished the current operation |
| ver_pass | input | 1 | Verify result, valid with `eng_done` |
| rd_data | output | DATA_W | Register read-back |
| acc_rd | output | 3 | Access field read-back (0 or 7) |
| prog_start | output | 1 | One-cycle program start strobe |
| ver_start | output | 1 | One-cycle verify start strobe |
| prog_pend | output | 1 | Program request bit |
| ver_pend | output | 1 | Verify request bit |
| crc_flt | output | 1 | Verify fault status |

## Verification
The bench targets several key-entry faults:
- A repeated 2 or a stray 5 in the middle of the key. A design that did not restart would unlock early.
- A write of 2 right after unlock. A design that treated it as a fresh first key would unlock again two writes later.
- A program attempt while locked, and one with prerequisites low. A design that checked the field after the write instead of before it, or ignored `prereq_ok`, would fire `prog_start`.
- A write setting both request bits, and requests made while busy. A faulty design would start the engine twice.
- An `eng_done` with no verify pending. A design that latched the fault bit on any completion would corrupt it.

// File: rtl/otp_unlock_pkg.sv
package otp_unlock_pkg;
  localparam int unsigned ACC_W    = 3;
  localparam int unsigned PROG_BIT = 0;
  localparam int unsigned ACC_LSB  = 1;
  localparam int unsigned VER_BIT  = ACC_LSB + ACC_W;

  localparam logic [ACC_W-1:0] KEY_FIRST  = 3'd2;
  localparam logic [ACC_W-1:0] KEY_SECOND = 3'd1;
  localparam logic [ACC_W-1:0] KEY_THIRD  = 3'd4;
  localparam logic [ACC_W-1:0] ACC_OPEN   = 3'd7;
  localparam logic [ACC_W-1:0] ACC_SHUT   = 3'd0;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HAVE1 = 2'd1,
    SEQ_HAVE2 = 2'd2,
    SEQ_OPEN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/otp_rst_sync.sv
module otp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/otp_key_seq.sv
module otp_key_seq
  import otp_unlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ACC_W-1:0] key_val,
  output logic             unlocked,
  output logic [ACC_W-1:0] acc_rd
);
  seq_state_e state_q, state_d;

  // Next state: every write either advances the key or falls back to idle.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  state_d = (key_val == KEY_FIRST)  ? SEQ_HAVE1 : SEQ_IDLE;
      SEQ_HAVE1: state_d = (key_val == KEY_SECOND) ? SEQ_HAVE2 : SEQ_IDLE;
      SEQ_HAVE2: state_d = (key_val == KEY_THIRD)  ? SEQ_OPEN  : SEQ_IDLE;
      SEQ_OPEN:  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else if (wr_en) begin
      state_q <= state_d;
    end
  end

  assign unlocked = (state_q == SEQ_OPEN);
  assign acc_rd   = unlocked ? ACC_OPEN : ACC_SHUT;
endmodule

// File: rtl/otp_req_ctrl.sv
module otp_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_prog,
  input  logic wr_ver,
  input  logic unlocked,
  input  logic prereq_ok,
  input  logic eng_busy,
  input  logic eng_done,
  input  logic ver_pass,
  output logic prog_pend,
  output logic ver_pend,
  output logic prog_start,
  output logic ver_start,
  output logic crc_flt
);
  logic prog_q, prog_d;
  logic ver_q, ver_d;
  logic pstart_q, pstart_d;
  logic vstart_q, vstart_d;
  logic crc_q, crc_d;
  logic busy, wr_ok, prog_acc, ver_acc, done_p, done_v, crc_en;

  always_comb begin
    busy     = prog_q | ver_q | eng_busy;
    wr_ok    = wr_en & ~busy & ~(wr_prog & wr_ver);
    prog_acc = wr_ok & wr_prog & unlocked & prereq_ok;
    ver_acc  = wr_ok & wr_ver;
    done_p   = eng_done & prog_q;
    done_v   = eng_done & ver_q;

    prog_d = prog_q;
    if (prog_acc)    prog_d = 1'b1;
    else if (done_p) prog_d = 1'b0;

    ver_d = ver_q;
    if (ver_acc)     ver_d = 1'b1;
    else if (done_v) ver_d = 1'b0;

    pstart_d = prog_acc;
    vstart_d = ver_acc;

    crc_en = done_v;
    crc_d  = ~ver_pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q   <= 1'b0;
      ver_q    <= 1'b0;
      pstart_q <= 1'b0;
      vstart_q <= 1'b0;
    end else begin
      prog_q   <= prog_d;
      ver_q    <= ver_d;
      pstart_q <= pstart_d;
      vstart_q <= vstart_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 1'b0;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign prog_pend  = prog_q;
  assign ver_pend   = ver_q;
  assign prog_start = pstart_q;
  assign ver_start  = vstart_q;
  assign crc_flt    = crc_q;
endmodule

// File: rtl/otp_unlock_ctrl.sv
module otp_unlock_ctrl
  import otp_unlock_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prereq_ok,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              ver_pass,
  output logic [DATA_W-1:0] rd_data,
  output logic [ACC_W-1:0]  acc_rd,
  output logic              prog_start,
  output logic              ver_start,
  output logic              prog_pend,
  output logic              ver_pend,
  output logic              crc_flt
);
  logic srst_n;
  logic unlocked;
  logic unused_wr_hi;

  otp_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  otp_key_seq u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .key_val  (wr_data[ACC_LSB +: ACC_W]),
    .unlocked (unlocked),
    .acc_rd   (acc_rd)
  );

  otp_req_ctrl u_req (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (wr_en),
    .wr_prog    (wr_data[PROG_BIT]),
    .wr_ver     (wr_data[VER_BIT]),
    .unlocked   (unlocked),
    .prereq_ok  (prereq_ok),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .ver_pass   (ver_pass),
    .prog_pend  (prog_pend),
    .ver_pend   (ver_pend),
    .prog_start (prog_start),
    .ver_start  (ver_start),
    .crc_flt    (crc_flt)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[PROG_BIT]           = prog_pend;
    rd_data[ACC_LSB +: ACC_W]   = acc_rd;
    rd_data[VER_BIT]            = ver_pend;
  end

  assign unused_wr_hi = ^wr_data[DATA_W-1:VER_BIT+1];
endmodule

// File: rtl/otp_unlock_ctrl_chk.sv
module otp_unlock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       prereq_ok,
  input logic       eng_done,
  input logic [2:0] acc_rd,
  input logic       prog_start,
  input logic       ver_start,
  input logic       prog_pend,
  input logic       ver_pend,
  input logic       crc_flt
);
  // R2
  acc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd == 3'd0) || (acc_rd == 3'd7));

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd == 3'd7 && wr_en) |=> (acc_rd == 3'd0));

  // R5
  prog_start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> prog_pend);

  // R6
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(acc_rd) == 3'd7 && $past(prereq_ok) && $past(wr_en)));

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_pend && ver_pend));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pend || ver_pend) |=> !(prog_start || ver_start));

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && (prog_pend || ver_pend)) |=> !(prog_pend || ver_pend));

  // R11
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ver_pend && eng_done) |=> $stable(crc_flt));

  // R12
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R12
  ver_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ver_start |=> !ver_start);
endmodule

bind otp_unlock_ctrl otp_unlock_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .prereq_ok  (prereq_ok),
  .eng_done   (eng_done),
  .acc_rd     (acc_rd),
  .prog_start (prog_start),
  .ver_start  (ver_start),
  .prog_pend  (prog_pend),
  .ver_pend   (ver_pend),
  .crc_flt    (crc_flt)
);

// File: tb/otp_unlock_ctrl_tb.sv
module otp_unlock_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              prereq_ok, eng_busy, eng_done, ver_pass;
  logic [DATA_W-1:0] rd_data;
  logic [2:0]        acc_rd;
  logic              prog_start, ver_start, prog_pend, ver_pend, crc_flt;

  int checks = 0;
  int fails  = 0;

  // expected: {rd[4:0], prog_start, ver_start, crc_flt}
  logic [7:0] exp_q[$];
  string      tag_q[$];

  int m_st;
  bit m_p, m_v, m_crc;

  always #(CLK_P/2) clk = ~clk;

  otp_unlock_ctrl #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .prereq_ok(prereq_ok), .eng_busy(eng_busy), .eng_done(eng_done),
    .ver_pass(ver_pass), .rd_data(rd_data), .acc_rd(acc_rd),
    .prog_start(prog_start), .ver_start(ver_start), .prog_pend(prog_pend),
    .ver_pend(ver_pend), .crc_flt(crc_flt)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outcome.
  task automatic step(input string tag, input bit wr, input bit v, input bit [2:0] acc,
                      input bit p, input bit pre, input bit bsy, input bit dn, input bit pass);
    bit unl, busy_m, ps, vs;
    @(negedge clk);
    wr_en     = wr;
    wr_data   = '0;
    wr_data[4]   = v;
    wr_data[3:1] = acc;
    wr_data[0]   = p;
    prereq_ok = pre;
    eng_busy  = bsy;
    eng_done  = dn;
    ver_pass  = pass;
    unl    = (m_st == 3);
    busy_m = m_p | m_v | bsy;
    ps = 0; vs = 0;
    if (dn) begin
      if (m_v) m_crc = !pass;
      m_p = 0; m_v = 0;
    end
    if (wr) begin
      case (m_st)
        0: m_st = (acc == 3'd2) ? 1 : 0;
        1: m_st = (acc == 3'd1) ? 2 : 0;
        2: m_st = (acc == 3'd4) ? 3 : 0;
        default: m_st = 0;
      endcase
      if (!busy_m && !(p && v)) begin
        if (p && unl && pre) begin m_p = 1; ps = 1; end
        if (v) begin m_v = 1; vs = 1; end
      end
    end
    exp_q.push_back({m_v, (m_st == 3) ? 3'd7 : 3'd0, m_p, ps, vs, m_crc});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input string tag, input bit v, input bit [2:0] acc, input bit p, input bit pre);
    step(tag, 1, v, acc, p, pre, 0, 0, 0);
  endtask

  task automatic idle(input string tag, input bit bsy, input bit dn, input bit pass);
    step(tag, 0, 0, 3'd0, 0, 1, bsy, dn, pass);
  endtask

  task automatic unlock(input string tag);
    wr(tag, 0, 3'd2, 0, 1);
    wr(tag, 0, 3'd1, 0, 1);
    wr(tag, 0, 3'd4, 0, 1);
  endtask

  // Monitor: pops one expected item per cycle, a quarter period after the edge.
  always @(posedge clk) begin
    logic [7:0] e, a;
    string t;
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {rd_data[4:0], prog_start, ver_start, crc_flt};
      checks++;
      if (a !== e || acc_rd !== e[6:4]) begin
        fails++;
        $display("FAIL %s act=%b acc=%0d exp=%b", t, a, acc_rd, e);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_st = 0; m_p = 0; m_v = 0; m_crc = 0;
    rst_n = 1'b0; wr_en = 0; wr_data = '0;
    prereq_ok = 0; eng_busy = 0; eng_done = 0; ver_pass = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 strobes/flt", {13'd0, prog_start, ver_start, crc_flt}, 16'h0);

    unlock("R2 key 2,1,4");
    wr("R4 relock by 0", 0, 3'd0, 0, 1);
    unlock("R2 second unlock");
    wr("R4 relock by 2", 0, 3'd2, 0, 1);
    wr("R4 no restart 1", 0, 3'd1, 0, 1);
    wr("R4 no restart 4", 0, 3'd4, 0, 1);

    wr("R3 2", 0, 3'd2, 0, 1);
    wr("R3 repeat 2", 0, 3'd2, 0, 1);
    wr("R3 1", 0, 3'd1, 0, 1);
    wr("R3 4", 0, 3'd4, 0, 1);
    wr("R3 2b", 0, 3'd2, 0, 1);
    wr("R3 1b", 0, 3'd1, 0, 1);
    wr("R3 stray 5", 0, 3'd5, 0, 1);
    unlock("R3 clean unlock");

    wr("R5 program accepted", 0, 3'd0, 1, 1);
    idle("R12 prog strobe drops", 0, 0, 0);
    wr("R9 verify while prog pending", 1, 3'd0, 0, 1);
    idle("R10 prog done", 0, 1, 1);
    idle("R10 prog cleared", 0, 0, 0);

    wr("R6 program while locked", 0, 3'd0, 1, 1);
    unlock("R6 unlock");
    wr("R6 program prereq low", 0, 3'd0, 1, 0);
    unlock("R8 unlock");
    wr("R8 both bits", 1, 3'd0, 1, 1);
    idle("R8 after reject", 0, 0, 0);

    wr("R7 verify request", 1, 3'd0, 0, 1);
    idle("R12 ver strobe drops", 0, 0, 0);
    idle("R11 verify fails", 0, 1, 0);
    idle("R11 stray done", 0, 1, 1);
    step("R9 engine busy", 1, 1, 3'd0, 0, 1, 1, 0, 0);
    wr("R7 verify again", 1, 3'd0, 0, 1);
    idle("R11 verify passes", 0, 1, 1);
    unlock("R5 unlock again");
    wr("R5 program again", 0, 3'd0, 1, 1);
    idle("R10 done again", 0, 1, 0);
    idle("R11 held after prog done", 0, 0, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule